// File: doc/BRIEF.md
# Mixed Integer/Floating-Point Pipeline Interlock

This block is the purely combinational hazard control for an in-order pipeline with two skewed paths of equal depth. Integer work runs through EX and ME and then rides the shared FP3, FP4 and FP5 stages to write-back. Floating-point arithmetic runs FP1 through FP5. Because of this skew, the set of pipeline registers that can hold a conflicting producer depends on the class of the consuming instruction.

For the instruction in decode, the block takes its class and two source register numbers. For each tracked pipeline register it takes a valid bit, a destination register, a register-file flag and the producer's class. It raises one stall line. The surrounding pipeline uses that line to freeze the program counter and the fetch/decode register, and to load a bubble into both the decode/EX and the decode/FP1 registers. The block also produces operand-select codes for the EX stage and the FP1 stage. Each select picks the youngest matching producer, or the register-file value when no producer matches.

Instruction classes are encoded as: 0 none, 1 integer ALU, 2 integer load, 3 integer store, 4 FP load, 5 FP arithmetic, 6 FP store, 7 unused. The slot index order is: 0 decode/EX, 1 EX/ME, 2 FP1/FP2, 3 ME/FP3, 4 FP2/FP3, 5 FP3/FP4, 6 FP4/FP5, 7 FP5/WB. There is no sequential state. The structure is a single idle/evaluate decision made anew on every input change.

Top module: `ilk_interlock`

## Requirements
- R1: Class codes are 0 none, 1 int ALU, 2 int load, 3 int store, 4 FP load, 5 FP arith, 6 FP store, 7 unused; with class 0 or 7 in decode, stall is low.
- R2: The integer-side operands are both sources for classes 1 and 3, source A for classes 2, 4 and 6. Stall is high when slot 0 holds a matching class-2 producer in the integer file.
- R3: For class 5 in decode, stall is high when either FP source matches one of these: a class-4 producer in slot 0, or a class-5 producer in slot 2, 4 or 5.
- R4: For class 6 in decode, source B is the FP data operand. Stall is high when B matches a class-5 producer in slot 2, 4 or 5, or any FP-file producer in slot 3.
- R5: Producers in slots 1, 6 and 7 never cause a stall, and a class-5 decode instruction ignores slot 3.
- R6: A slot matches a source only when all of these hold: its valid bit is 1, its class writes a register (1, 2, 4 or 5), its file flag (1 = FP) equals the operand's file, and its destination equals the source. Integer register 0 never matches. Slot bit order is 0 decode/EX, 1 EX/ME, 2 FP1/FP2, 3 ME/FP3, 4 FP2/FP3, 5 FP3/FP4, 6 FP4/FP5, 7 FP5/WB.
- R7: Each EX select compares its integer source against the integer file. The codes are 0 register file, 1 EX/ME, 2 ME/FP3, 3 FP3/FP4, 4 FP4/FP5, 5 FP5/WB.
- R8: Each FP1 select compares its source against the FP file. The codes are 0 register file, 1 ME/FP3, 2 FP3/FP4, 3 FP4/FP5, 4 FP5/WB.
- R9: When several slots match one operand, the select gives the youngest, which is the lowest nonzero code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_cls | input | 3 | Class of the decode instruction |
| id_src_a | input | RW | Decode source A |
| id_src_b | input | RW | Decode source B |
| ex_src_a | input | RW | Integer source A of the instruction entering EX |
| ex_src_b | input | RW | Integer source B of the instruction entering EX |
| fp1_src_a | input | RW | FP source A of the instruction entering FP1 |
| fp1_src_b | input | RW | FP source B of the instruction entering FP1 |
| slot_vld | input | 8 | Valid bit per tracked pipeline register |
| slot_fp | input | 8 | Destination file per slot, 1 = FP |
| slot_cls | input | 8 x 3 | Producer class per slot |
| slot_dst | input | 8 x RW | Destination register per slot |
| stall | output | 1 | Hold PC and fetch/decode, bubble both decode outputs |
| ex_sel_a | output | 3 | EX operand A source code |
| ex_sel_b | output | 3 | EX operand B source code |
| fp1_sel_a | output | 3 | FP1 operand A source code |
| fp1_sel_b | output | 3 | FP1 operand B source code |

## Verification
Every output is a combinational function of the current inputs, so the stall line and all four select codes are due in the same cycle as the stimulus that produces them. The bench changes inputs just after a rising edge and samples at the following falling edge, which leaves half a period for the logic to settle. No result is read across an edge. Directed vectors cover the skew-specific cases: the ME/FP3 check that applies only to FP stores, register 0, file mismatch and multiple matches. Seeded random vectors with a small register range exercise overlapping matches.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

    typedef enum logic [2:0] {
        CL_NONE   = 3'd0,
        CL_IALU   = 3'd1,
        CL_ILOAD  = 3'd2,
        CL_ISTORE = 3'd3,
        CL_FLOAD  = 3'd4,
        CL_FARITH = 3'd5,
        CL_FSTORE = 3'd6
    } cls_e;

    // tracked pipeline registers, youngest first on each path
    localparam int NSLOT    = 8;
    localparam int SL_IDEX  = 0;
    localparam int SL_EXME  = 1;
    localparam int SL_FP12  = 2;
    localparam int SL_MEFP3 = 3;
    localparam int SL_FP23  = 4;
    localparam int SL_FP34  = 5;
    localparam int SL_FP45  = 6;
    localparam int SL_FP5WB = 7;

    // candidate list sizes per consumer operand
    localparam int N_FA    = 4;
    localparam int N_FB    = 5;
    localparam int N_EXSRC = 5;
    localparam int N_F1SRC = 4;
    localparam int EXSEL_W = $clog2(N_EXSRC + 1);
    localparam int F1SEL_W = $clog2(N_F1SRC + 1);

    function automatic logic cls_writes(input logic [2:0] c);
        return (c == CL_IALU) || (c == CL_ILOAD) ||
               (c == CL_FLOAD) || (c == CL_FARITH);
    endfunction

endpackage

// File: rtl/ilk_slot_match.sv
module ilk_slot_match
    import ilk_pkg::*;
#(
    parameter int RW = 5
) (
    input  logic          vld,
    input  logic          is_fp,
    input  logic [2:0]    cls,
    input  logic [RW-1:0] dst,
    input  logic [RW-1:0] src,
    input  logic          want_fp,
    output logic          hit
);
    always_comb begin
        hit = vld && cls_writes(cls) && (is_fp == want_fp) &&
              (dst == src) && (want_fp || (|src));
    end
endmodule

// File: rtl/ilk_src_scan.sv
module ilk_src_scan
    import ilk_pkg::*;
#(
    parameter int RW = 5,
    parameter int N  = 4
) (
    input  logic [N-1:0]         vld,
    input  logic [N-1:0]         is_fp,
    input  logic [N-1:0][2:0]    cls,
    input  logic [N-1:0][RW-1:0] dst,
    input  logic [RW-1:0]        src,
    input  logic                 want_fp,
    output logic [N-1:0]         hit
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        ilk_slot_match #(.RW(RW)) u_m (
            .vld(vld[i]), .is_fp(is_fp[i]), .cls(cls[i]), .dst(dst[i]),
            .src(src), .want_fp(want_fp), .hit(hit[i])
        );
    end
endmodule

// File: rtl/ilk_fwd_pick.sv
module ilk_fwd_pick #(
    parameter int N  = 5,
    parameter int SW = $clog2(N + 1)
) (
    input  logic [N-1:0]  cand,
    output logic [SW-1:0] code
);
    // bit 0 is the youngest producer; it wins by being visited last
    always_comb begin
        code = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) code = SW'(i + 1);
        end
    end
endmodule

// File: rtl/ilk_stall_ctl.sv
module ilk_stall_ctl
    import ilk_pkg::*;
(
    input  logic [2:0]      id_cls,
    input  logic            ia_hit,
    input  logic            ib_hit,
    input  logic [N_FA-1:0] fa_hit,   // IDEX, FP12, FP23, FP34
    input  logic [N_FB-1:0] fb_hit,   // IDEX, FP12, MEFP3, FP23, FP34
    input  logic [2:0]      cls_idex,
    input  logic [2:0]      cls_fp12,
    input  logic [2:0]      cls_fp23,
    input  logic [2:0]      cls_fp34,
    output logic            stall
);
    logic ild, fld, ar12, ar23, ar34;
    logic int_a, int_b, fa_hz, fb_hz, st_hz;

    always_comb begin
        ild   = (cls_idex == CL_ILOAD);
        fld   = (cls_idex == CL_FLOAD);
        ar12  = (cls_fp12 == CL_FARITH);
        ar23  = (cls_fp23 == CL_FARITH);
        ar34  = (cls_fp34 == CL_FARITH);
        int_a = ia_hit && ild;
        int_b = ib_hit && ild;
        fa_hz = (fa_hit[0] && fld) || (fa_hit[1] && ar12) ||
                (fa_hit[2] && ar23) || (fa_hit[3] && ar34);
        fb_hz = (fb_hit[0] && fld) || (fb_hit[1] && ar12) ||
                (fb_hit[3] && ar23) || (fb_hit[4] && ar34);
        st_hz = (fb_hit[1] && ar12) || fb_hit[2] ||
                (fb_hit[3] && ar23) || (fb_hit[4] && ar34);
    end

    always_comb begin
        unique case (id_cls)
            CL_IALU, CL_ISTORE: stall = int_a || int_b;
            CL_ILOAD, CL_FLOAD: stall = int_a;
            CL_FARITH:          stall = fa_hz || fb_hz;
            CL_FSTORE:          stall = int_a || st_hz;
            default:            stall = 1'b0;
        endcase
    end
endmodule

// File: rtl/ilk_interlock.sv
module ilk_interlock
    import ilk_pkg::*;
#(
    parameter int RW = 5
) (
    input  logic [2:0]                 id_cls,
    input  logic [RW-1:0]              id_src_a,
    input  logic [RW-1:0]              id_src_b,
    input  logic [RW-1:0]              ex_src_a,
    input  logic [RW-1:0]              ex_src_b,
    input  logic [RW-1:0]              fp1_src_a,
    input  logic [RW-1:0]              fp1_src_b,
    input  logic [NSLOT-1:0]           slot_vld,
    input  logic [NSLOT-1:0]           slot_fp,
    input  logic [NSLOT-1:0][2:0]      slot_cls,
    input  logic [NSLOT-1:0][RW-1:0]   slot_dst,
    output logic                       stall,
    output logic [EXSEL_W-1:0]         ex_sel_a,
    output logic [EXSEL_W-1:0]         ex_sel_b,
    output logic [F1SEL_W-1:0]         fp1_sel_a,
    output logic [F1SEL_W-1:0]         fp1_sel_b
);
    localparam int FA_L [N_FA]    = '{SL_IDEX, SL_FP12, SL_FP23, SL_FP34};
    localparam int FB_L [N_FB]    = '{SL_IDEX, SL_FP12, SL_MEFP3, SL_FP23, SL_FP34};
    localparam int EX_L [N_EXSRC] = '{SL_EXME, SL_MEFP3, SL_FP34, SL_FP45, SL_FP5WB};
    localparam int F1_L [N_F1SRC] = '{SL_MEFP3, SL_FP34, SL_FP45, SL_FP5WB};

    logic [N_FA-1:0]            fa_v, fa_f, fa_hit;
    logic [N_FA-1:0][2:0]       fa_c;
    logic [N_FA-1:0][RW-1:0]    fa_d;
    logic [N_FB-1:0]            fb_v, fb_f, fb_hit;
    logic [N_FB-1:0][2:0]       fb_c;
    logic [N_FB-1:0][RW-1:0]    fb_d;
    logic [N_EXSRC-1:0]         ex_v, ex_f, exa_hit, exb_hit;
    logic [N_EXSRC-1:0][2:0]    ex_c;
    logic [N_EXSRC-1:0][RW-1:0] ex_d;
    logic [N_F1SRC-1:0]         f1_v, f1_f, f1a_hit, f1b_hit;
    logic [N_F1SRC-1:0][2:0]    f1_c;
    logic [N_F1SRC-1:0][RW-1:0] f1_d;
    logic                       ia_hit, ib_hit;

    for (genvar i = 0; i < N_FA; i++) begin : g_fa
        assign fa_v[i] = slot_vld[FA_L[i]];
        assign fa_f[i] = slot_fp[FA_L[i]];
        assign fa_c[i] = slot_cls[FA_L[i]];
        assign fa_d[i] = slot_dst[FA_L[i]];
    end
    for (genvar i = 0; i < N_FB; i++) begin : g_fb
        assign fb_v[i] = slot_vld[FB_L[i]];
        assign fb_f[i] = slot_fp[FB_L[i]];
        assign fb_c[i] = slot_cls[FB_L[i]];
        assign fb_d[i] = slot_dst[FB_L[i]];
    end
    for (genvar i = 0; i < N_EXSRC; i++) begin : g_ex
        assign ex_v[i] = slot_vld[EX_L[i]];
        assign ex_f[i] = slot_fp[EX_L[i]];
        assign ex_c[i] = slot_cls[EX_L[i]];
        assign ex_d[i] = slot_dst[EX_L[i]];
    end
    for (genvar i = 0; i < N_F1SRC; i++) begin : g_f1
        assign f1_v[i] = slot_vld[F1_L[i]];
        assign f1_f[i] = slot_fp[F1_L[i]];
        assign f1_c[i] = slot_cls[F1_L[i]];
        assign f1_d[i] = slot_dst[F1_L[i]];
    end

    // decode-stage integer operands only ever meet a load in decode/EX
    ilk_slot_match #(.RW(RW)) u_ia (
        .vld(slot_vld[SL_IDEX]), .is_fp(slot_fp[SL_IDEX]), .cls(slot_cls[SL_IDEX]),
        .dst(slot_dst[SL_IDEX]), .src(id_src_a), .want_fp(1'b0), .hit(ia_hit));
    ilk_slot_match #(.RW(RW)) u_ib (
        .vld(slot_vld[SL_IDEX]), .is_fp(slot_fp[SL_IDEX]), .cls(slot_cls[SL_IDEX]),
        .dst(slot_dst[SL_IDEX]), .src(id_src_b), .want_fp(1'b0), .hit(ib_hit));

    ilk_src_scan #(.RW(RW), .N(N_FA)) u_fa (.vld(fa_v), .is_fp(fa_f), .cls(fa_c),
        .dst(fa_d), .src(id_src_a), .want_fp(1'b1), .hit(fa_hit));
    ilk_src_scan #(.RW(RW), .N(N_FB)) u_fb (.vld(fb_v), .is_fp(fb_f), .cls(fb_c),
        .dst(fb_d), .src(id_src_b), .want_fp(1'b1), .hit(fb_hit));
    ilk_src_scan #(.RW(RW), .N(N_EXSRC)) u_exa (.vld(ex_v), .is_fp(ex_f), .cls(ex_c),
        .dst(ex_d), .src(ex_src_a), .want_fp(1'b0), .hit(exa_hit));
    ilk_src_scan #(.RW(RW), .N(N_EXSRC)) u_exb (.vld(ex_v), .is_fp(ex_f), .cls(ex_c),
        .dst(ex_d), .src(ex_src_b), .want_fp(1'b0), .hit(exb_hit));
    ilk_src_scan #(.RW(RW), .N(N_F1SRC)) u_f1a (.vld(f1_v), .is_fp(f1_f), .cls(f1_c),
        .dst(f1_d), .src(fp1_src_a), .want_fp(1'b1), .hit(f1a_hit));
    ilk_src_scan #(.RW(RW), .N(N_F1SRC)) u_f1b (.vld(f1_v), .is_fp(f1_f), .cls(f1_c),
        .dst(f1_d), .src(fp1_src_b), .want_fp(1'b1), .hit(f1b_hit));

    ilk_fwd_pick #(.N(N_EXSRC), .SW(EXSEL_W)) u_pexa (.cand(exa_hit), .code(ex_sel_a));
    ilk_fwd_pick #(.N(N_EXSRC), .SW(EXSEL_W)) u_pexb (.cand(exb_hit), .code(ex_sel_b));
    ilk_fwd_pick #(.N(N_F1SRC), .SW(F1SEL_W)) u_pf1a (.cand(f1a_hit), .code(fp1_sel_a));
    ilk_fwd_pick #(.N(N_F1SRC), .SW(F1SEL_W)) u_pf1b (.cand(f1b_hit), .code(fp1_sel_b));

    ilk_stall_ctl u_stall (
        .id_cls(id_cls), .ia_hit(ia_hit), .ib_hit(ib_hit),
        .fa_hit(fa_hit), .fb_hit(fb_hit),
        .cls_idex(slot_cls[SL_IDEX]), .cls_fp12(slot_cls[SL_FP12]),
        .cls_fp23(slot_cls[SL_FP23]), .cls_fp34(slot_cls[SL_FP34]),
        .stall(stall));
endmodule

// File: rtl/ilk_interlock_chk.sv
module ilk_interlock_chk
    import ilk_pkg::*;
#(
    parameter int RW = 5
) (
    input logic [2:0]         id_cls,
    input logic               stall,
    input logic               idex_vld,
    input logic [2:0]         idex_cls,
    input logic               exme_vld,
    input logic [RW-1:0]      ex_src_a,
    input logic [EXSEL_W-1:0] ex_sel_a,
    input logic [EXSEL_W-1:0] ex_sel_b,
    input logic [F1SEL_W-1:0] fp1_sel_a,
    input logic [F1SEL_W-1:0] fp1_sel_b
);
    always_comb begin
        if (id_cls == CL_NONE || id_cls == 3'd7)
            AST_IDLE_QUIET: assert (!stall); // R1
        if ((id_cls == CL_IALU || id_cls == CL_ILOAD || id_cls == CL_ISTORE) && stall)
            AST_INT_STALL_CAUSE: assert (idex_vld && idex_cls == CL_ILOAD); // R2
        AST_EX_SEL_RANGE: assert (int'(ex_sel_a) <= N_EXSRC && int'(ex_sel_b) <= N_EXSRC); // R7
        AST_F1_SEL_RANGE: assert (int'(fp1_sel_a) <= N_F1SRC && int'(fp1_sel_b) <= N_F1SRC); // R8
        if (ex_src_a == '0)
            AST_REG0_NO_FWD: assert (ex_sel_a == '0); // R6
        if (ex_sel_a == EXSEL_W'(1))
            AST_EXME_FWD_VALID: assert (exme_vld); // R9
    end
endmodule

bind ilk_interlock ilk_interlock_chk #(.RW(RW)) u_chk (
    .id_cls(id_cls), .stall(stall),
    .idex_vld(slot_vld[0]), .idex_cls(slot_cls[0]), .exme_vld(slot_vld[1]),
    .ex_src_a(ex_src_a), .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b),
    .fp1_sel_a(fp1_sel_a), .fp1_sel_b(fp1_sel_b)
);

// File: tb/ilk_interlock_test.sv
module ilk_interlock_test;
    localparam int RW = 5;
    localparam int NS = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [2:0]             id_cls;
    logic [RW-1:0]          id_src_a, id_src_b, ex_src_a, ex_src_b, fp1_src_a, fp1_src_b;
    logic [NS-1:0]          slot_vld, slot_fp;
    logic [NS-1:0][2:0]     slot_cls;
    logic [NS-1:0][RW-1:0]  slot_dst;
    logic                   stall;
    logic [2:0]             ex_sel_a, ex_sel_b, fp1_sel_a, fp1_sel_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    ilk_interlock #(.RW(RW)) uut (
        .id_cls(id_cls), .id_src_a(id_src_a), .id_src_b(id_src_b),
        .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
        .fp1_src_a(fp1_src_a), .fp1_src_b(fp1_src_b),
        .slot_vld(slot_vld), .slot_fp(slot_fp), .slot_cls(slot_cls), .slot_dst(slot_dst),
        .stall(stall), .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b),
        .fp1_sel_a(fp1_sel_a), .fp1_sel_b(fp1_sel_b));

    // reference model, written from the requirements
    function automatic bit m_hit(input int s, input logic [RW-1:0] src, input bit want_fp);
        int c = int'(slot_cls[s]);
        bit wr = (c == 1) || (c == 2) || (c == 4) || (c == 5);
        return slot_vld[s] && wr && (slot_fp[s] == want_fp) &&
               (slot_dst[s] == src) && (want_fp || src != 0);
    endfunction

    function automatic bit m_arith(input int s);
        return int'(slot_cls[s]) == 5;
    endfunction

    function automatic bit m_fp_hz(input logic [RW-1:0] src);
        return (m_hit(0, src, 1) && int'(slot_cls[0]) == 4) ||
               (m_hit(2, src, 1) && m_arith(2)) || (m_hit(4, src, 1) && m_arith(4)) ||
               (m_hit(5, src, 1) && m_arith(5));
    endfunction

    function automatic bit m_stall();
        bit ia = m_hit(0, id_src_a, 0) && int'(slot_cls[0]) == 2;
        bit ib = m_hit(0, id_src_b, 0) && int'(slot_cls[0]) == 2;
        case (int'(id_cls))
            1, 3: return ia || ib;
            2, 4: return ia;
            5:    return m_fp_hz(id_src_a) || m_fp_hz(id_src_b);
            6:    return ia || m_hit(3, id_src_b, 1) ||
                         (m_hit(2, id_src_b, 1) && m_arith(2)) ||
                         (m_hit(4, id_src_b, 1) && m_arith(4)) ||
                         (m_hit(5, id_src_b, 1) && m_arith(5));
            default: return 1'b0;
        endcase
    endfunction

    function automatic int m_ex_sel(input logic [RW-1:0] src);
        int lst [5] = '{1, 3, 5, 6, 7};
        for (int k = 0; k < 5; k++) if (m_hit(lst[k], src, 0)) return k + 1;
        return 0;
    endfunction

    function automatic int m_f1_sel(input logic [RW-1:0] src);
        int lst [4] = '{3, 5, 6, 7};
        for (int k = 0; k < 4; k++) if (m_hit(lst[k], src, 1)) return k + 1;
        return 0;
    endfunction

    task automatic chk(input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, got, exp);
        end
    endtask

    task automatic chk_model(input string tag);
        chk({tag, " stall"},     int'(stall),     int'(m_stall()));
        chk({tag, " ex_sel_a"},  int'(ex_sel_a),  m_ex_sel(ex_src_a));
        chk({tag, " ex_sel_b"},  int'(ex_sel_b),  m_ex_sel(ex_src_b));
        chk({tag, " fp1_sel_a"}, int'(fp1_sel_a), m_f1_sel(fp1_src_a));
        chk({tag, " fp1_sel_b"}, int'(fp1_sel_b), m_f1_sel(fp1_src_b));
    endtask

    task automatic clear_in();
        id_cls = '0; id_src_a = '0; id_src_b = '0; ex_src_a = '0; ex_src_b = '0;
        fp1_src_a = '0; fp1_src_b = '0;
        slot_vld = '0; slot_fp = '0; slot_cls = '0; slot_dst = '0;
    endtask

    task automatic put(input int s, input int c, input bit fp, input int d);
        slot_vld[s] = 1'b1; slot_cls[s] = 3'(c); slot_fp[s] = fp; slot_dst[s] = RW'(d);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        clear_in();

        // R1 idle state: quiet outputs
        @(negedge clk);
        chk("R1 idle stall", int'(stall), 0);
        chk("R1 idle ex_sel_a", int'(ex_sel_a), 0);
        chk("R7 idle fp1_sel_a", int'(fp1_sel_a), 0);

        // R2 load-use on integer source A
        @(posedge clk); #1; clear_in();
        id_cls = 3'd1; id_src_a = 5'd3; put(0, 2, 0, 3);
        @(negedge clk); chk("R2 int load-use stall", int'(stall), 1); chk_model("R2");

        // R6 register 0 never matches
        @(posedge clk); #1; clear_in();
        id_cls = 3'd1; put(0, 2, 0, 0); put(1, 1, 0, 0);
        @(negedge clk);
        chk("R6 reg0 stall", int'(stall), 0);
        chk("R6 reg0 ex_sel_a", int'(ex_sel_a), 0);

        // R6 file mismatch and non-writing store
        @(posedge clk); #1; clear_in();
        id_cls = 3'd1; id_src_a = 5'd3; put(0, 2, 1, 3);
        ex_src_a = 5'd9; put(1, 3, 0, 9);
        @(negedge clk);
        chk("R6 file mismatch stall", int'(stall), 0);
        chk("R6 store not producer ex_sel_a", int'(ex_sel_a), 0);

        // R3 FP arith against FP2/FP3 arithmetic producer
        @(posedge clk); #1; clear_in();
        id_cls = 3'd5; id_src_b = 5'd5; put(4, 5, 1, 5);
        @(negedge clk); chk("R3 fp arith stall", int'(stall), 1);

        // R4 FP store data against load in ME/FP3
        @(posedge clk); #1; clear_in();
        id_cls = 3'd6; id_src_b = 5'd6; put(3, 4, 1, 6);
        @(negedge clk); chk("R4 fp store ME/FP3 stall", int'(stall), 1);

        // R5 FP arith ignores ME/FP3
        @(posedge clk); #1; id_cls = 3'd5;
        @(negedge clk); chk("R5 fp arith ignores ME/FP3", int'(stall), 0);

        // R5 FP4/FP5 producer forwards instead of stalling; R8 code 3
        @(posedge clk); #1; clear_in();
        id_cls = 3'd5; id_src_a = 5'd4; put(6, 5, 1, 4); fp1_src_a = 5'd4;
        @(negedge clk);
        chk("R5 FP4/FP5 no stall", int'(stall), 0);
        chk("R8 fp1_sel_a from FP4/FP5", int'(fp1_sel_a), 3);

        // R8 integer producer not forwarded to FP1
        @(posedge clk); #1; clear_in();
        fp1_src_b = 5'd2; put(3, 1, 0, 2);
        @(negedge clk); chk("R8 int not to FP1", int'(fp1_sel_b), 0);

        // R9 youngest wins, then falls back to oldest
        @(posedge clk); #1; clear_in();
        ex_src_a = 5'd7; put(1, 1, 0, 7); put(7, 1, 0, 7);
        @(negedge clk); chk("R9 youngest ex_sel_a", int'(ex_sel_a), 1);
        @(posedge clk); #1; slot_vld[1] = 1'b0;
        @(negedge clk); chk("R7 FP5/WB ex_sel_a", int'(ex_sel_a), 5);

        // R1 unused class 7 with matching load
        @(posedge clk); #1; clear_in();
        id_cls = 3'd7; id_src_a = 5'd3; put(0, 2, 0, 3);
        @(negedge clk); chk("R1 class7 no stall", int'(stall), 0);

        // constrained random, small register range to force matches
        for (int n = 0; n < 4000; n++) begin
            @(posedge clk); #1;
            id_cls    = 3'($urandom_range(7, 0));
            id_src_a  = RW'($urandom_range(3, 0));
            id_src_b  = RW'($urandom_range(3, 0));
            ex_src_a  = RW'($urandom_range(3, 0));
            ex_src_b  = RW'($urandom_range(3, 0));
            fp1_src_a = RW'($urandom_range(3, 0));
            fp1_src_b = RW'($urandom_range(3, 0));
            for (int s = 0; s < NS; s++) begin
                slot_vld[s] = ($urandom_range(3, 0) != 0);
                slot_fp[s]  = 1'($urandom_range(1, 0));
                slot_cls[s] = 3'($urandom_range(7, 0));
                slot_dst[s] = RW'($urandom_range(3, 0));
            end
            @(negedge clk);
            chk_model("R2 R3 R4 R5 R6 R7 R8 R9 random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule